// File: doc/BRIEF.md
# Width-Extending ALU With Dual Carry

This block is the arithmetic unit and result shaping stage of a widened accumulator processor. The two accumulators are 16 bits wide and the index registers 32 bits wide. Each operation names a destination kind (single accumulator, the accumulator pair treated as one register, or an index register) and a width: legacy or wide. The block forms the operands for that combination and computes the result. It then lays the result out across the full 32-bit destination image and updates a registered set of condition flags. The result path is combinational. The flags change on the clock edge when the update enable is high.

Old narrow code must keep behaving as before inside the wider registers. To that end, a legacy result is sign-extended into the wider register, with shifts and rotates as the exception. Two carry flags are kept side by side. The legacy carry follows narrow rules, and the wide carry follows the full active width and feeds every wide operation.

Top module: `wide_acc_alu`

## Requirements
- R1: For a legacy non-shift operation on a single accumulator (dst 0), the result is the 8-bit value sign-extended over all 32 bits of res_o. For example, loading 0xFF yields 0xFFFFFFFF, so the 16-bit accumulator reads 0xFFFF.
- R2: For a wide non-shift operation on a single accumulator, the result is the 16-bit value sign-extended over all 32 bits of res_o.
- R3: For a legacy operation on the pair (dst 1, A = opa[31:16], B = opa[15:0]), the operand is {opa[23:16], opa[7:0]}. It is computed at 16 bits. The upper result byte is sign-extended into A and the lower byte into B. A wide pair operation uses all 32 bits.
- R4: For a legacy operation on an index register (dst 2, code 3 is treated the same), the 16-bit result is sign-extended to 32 bits, so loading 0x8000 gives 0xFFFF8000. A wide index operation uses all 32 bits.
- R5: For shifts and rotates, only the active-width bits, placed as for the destination, are replaced. Every other bit of res_o is taken from opa.
- R6: A legacy operation takes carry-in from the legacy carry C. It sets C from the carry out of the active top bit (bit 7 for dst 0, bit 15 for dst 1 and 2), or from bit 0 for right shifts and rotates. It leaves the wide carry W unchanged.
- R7: A wide operation takes carry-in from W. It sets W from the carry out of the active top bit (15 for dst 0, 31 otherwise) and sets C from the carry out of bit 7. For right shifts and rotates, both W and C take the value of bit 0.
- R8: Subtract, subtract-with-borrow, compare and negate report borrow as the carry, and subtract-with-borrow subtracts the incoming carry.
- R9: N, Z and V are computed at the active width before extension. Z tests only the active bits.
- R10: AND, OR, XOR and load clear V and keep both carries. Increment and decrement keep both carries. Complement clears V and sets the carries. Right shifts and right rotates keep V. Left shift and left rotate set V to N xor the new carry.
- R11: Compare drives res_o with opa unchanged and sets the flags as subtraction does.
- R12: On a clock edge with en_i high, flags_o = {W, N, Z, V, C} (bit 4 down to bit 0) takes the new flags. With en_i low it holds. An active-low reset clears it.
- R13: op_i codes are ADD 0, ADC 1, SUB 2, SBC 3, AND 4, OR 5, XOR 6, CMP 7, INC 8, DEC 9, NEG 10, COM 11, ASL 12, ASR 13, LSR 14, ROL 15, ROR 16 and LD 17 (loads opb). Any other code acts as LD. wide_i 0 selects legacy width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the flag register |
| en_i | input | 1 | Flag update enable |
| op_i | input | 5 | Operation code |
| wide_i | input | 1 | 1 selects wide width, 0 legacy width |
| dst_i | input | 2 | Destination kind: 0 accumulator, 1 pair, 2/3 index |
| opa_i | input | 32 | Destination register image / first operand |
| opb_i | input | 32 | Second operand |
| res_o | output | 32 | Shaped result for the destination |
| flags_o | output | 5 | Registered flags {W, N, Z, V, C} |

## Verification
Each operation class is applied across every pairing of destination kind and width. This separates the byte, 16-bit and 32-bit extension layouts and the per-byte fill of the pair. Carry-sensitive cases start from each of the four W/C presets. An add with carry then shows which carry is consumed and which is left alone. Operands are placed at carries out of bit 7 and bit 15, and at sign boundaries such as 0x7F+1 and negating 0x8000, so that a carry tapped at the wrong bit or a sign taken at the wrong width gives a different value. Opa carries non-zero upper bytes, so that an extension applied to shifts or a Z flag that looks at inactive bits shows up at the outputs.

// File: rtl/wxalu_pkg.sv
package wxalu_pkg;

   typedef enum logic [4:0] {
      OP_ADD = 5'd0,
      OP_ADC = 5'd1,
      OP_SUB = 5'd2,
      OP_SBC = 5'd3,
      OP_AND = 5'd4,
      OP_OR  = 5'd5,
      OP_XOR = 5'd6,
      OP_CMP = 5'd7,
      OP_INC = 5'd8,
      OP_DEC = 5'd9,
      OP_NEG = 5'd10,
      OP_COM = 5'd11,
      OP_ASL = 5'd12,
      OP_ASR = 5'd13,
      OP_LSR = 5'd14,
      OP_ROL = 5'd15,
      OP_ROR = 5'd16,
      OP_LD  = 5'd17
   } alu_op_e;

   typedef enum logic [1:0] {
      DST_ACC  = 2'd0,
      DST_PAIR = 2'd1,
      DST_IDX  = 2'd2,
      DST_IDXB = 2'd3
   } dst_e;

   typedef enum logic [1:0] {
      WD_BYTE = 2'd0,
      WD_HALF = 2'd1,
      WD_FULL = 2'd2,
      WD_RSVD = 2'd3
   } width_e;

   typedef struct packed {
      logic w;
      logic n;
      logic z;
      logic v;
      logic c;
   } flags_t;

   function automatic logic is_shift(input alu_op_e op);
      return (op == OP_ASL) || (op == OP_ASR) || (op == OP_LSR) ||
             (op == OP_ROL) || (op == OP_ROR);
   endfunction

   function automatic logic is_right(input alu_op_e op);
      return (op == OP_ASR) || (op == OP_LSR) || (op == OP_ROR);
   endfunction

   function automatic logic is_arith(input alu_op_e op);
      return (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) ||
             (op == OP_SBC) || (op == OP_CMP) || (op == OP_NEG) ||
             (op == OP_INC) || (op == OP_DEC);
   endfunction

endpackage

// File: rtl/wxalu_operand.sv
module wxalu_operand
   import wxalu_pkg::*;
#(
   parameter int NW = 8,
   parameter int AW = 16,
   parameter int XW = 32
) (
   input  dst_e            dst,
   input  logic            wide,
   input  logic [XW-1:0]   opa,
   input  logic [XW-1:0]   opb,
   output logic [XW-1:0]   x,
   output logic [XW-1:0]   y,
   output width_e          wsel
);

   localparam int HI_LO = AW;        // low bit of upper accumulator
   localparam int HI_HI = AW + NW;   // one past its low byte

   always_comb begin
      x    = opa;
      y    = opb;
      wsel = WD_FULL;
      case (dst)
         DST_ACC: begin
            wsel = wide ? WD_HALF : WD_BYTE;
         end
         DST_PAIR: begin
            if (!wide) begin
               // legacy pair: low byte of each accumulator, upper one on top
               x    = {{(XW-AW){1'b0}}, opa[HI_HI-1:HI_LO], opa[NW-1:0]};
               y    = {{(XW-AW){1'b0}}, opb[HI_HI-1:HI_LO], opb[NW-1:0]};
               wsel = WD_HALF;
            end
         end
         default: begin
            if (!wide) begin
               x    = {{(XW-AW){1'b0}}, opa[AW-1:0]};
               y    = {{(XW-AW){1'b0}}, opb[AW-1:0]};
               wsel = WD_HALF;
            end
         end
      endcase
   end

endmodule

// File: rtl/wxalu_core.sv
module wxalu_core
   import wxalu_pkg::*;
#(
   parameter int NW = 8,
   parameter int AW = 16,
   parameter int XW = 32
) (
   input  alu_op_e         op,
   input  width_e          wsel,
   input  logic [XW-1:0]   x,
   input  logic [XW-1:0]   y,
   input  logic            cin,
   output logic [XW-1:0]   r,
   output logic            co_lo,
   output logic            co_top,
   output logic            v_out,
   output logic            n_out,
   output logic            z_out
);

   localparam int NTAP = 3;

   logic [XW-1:0]   ax, ay;
   logic            acin, sub;
   logic [XW:0]     sfull;
   logic [NTAP-1:0] tap_c;
   logic            c_act;
   int              top;
   logic [XW-1:0]   mask;

   // adder operand selection
   always_comb begin
      ax   = x;
      ay   = y;
      acin = 1'b0;
      sub  = 1'b0;
      case (op)
         OP_ADD: acin = 1'b0;
         OP_ADC: acin = cin;
         OP_SUB, OP_CMP: begin
            ay = ~y; acin = 1'b1; sub = 1'b1;
         end
         OP_SBC: begin
            ay = ~y; acin = ~cin; sub = 1'b1;
         end
         OP_INC: begin
            ay = {{(XW-1){1'b0}}, 1'b1};
         end
         OP_DEC: begin
            ay = ~{{(XW-1){1'b0}}, 1'b1}; acin = 1'b1; sub = 1'b1;
         end
         OP_NEG: begin
            ax = '0; ay = ~x; acin = 1'b1; sub = 1'b1;
         end
         default: ;
      endcase
   end

   assign sfull = {1'b0, ax} + {1'b0, ay} + {{XW{1'b0}}, acin};

   // carry taps at each supported width
   for (genvar t = 0; t < NTAP; t++) begin : g_tap
      localparam int TW = (t == 0) ? NW : ((t == 1) ? AW : XW);
      if (TW == XW) begin : g_top
         assign tap_c[t] = sfull[XW];
      end else begin : g_mid
         assign tap_c[t] = sfull[TW] ^ ax[TW] ^ ay[TW];
      end
   end

   always_comb begin
      case (wsel)
         WD_BYTE: begin top = NW - 1; c_act = tap_c[0]; mask = {{(XW-NW){1'b0}}, {NW{1'b1}}}; end
         WD_HALF: begin top = AW - 1; c_act = tap_c[1]; mask = {{(XW-AW){1'b0}}, {AW{1'b1}}}; end
         default: begin top = XW - 1; c_act = tap_c[2]; mask = {XW{1'b1}}; end
      endcase
   end

   always_comb begin
      r      = sfull[XW-1:0];
      co_lo  = sub ? ~tap_c[0] : tap_c[0];
      co_top = sub ? ~c_act : c_act;
      v_out  = (ax[top] == ay[top]) && (sfull[top] != ax[top]);
      case (op)
         OP_AND: r = x & y;
         OP_OR:  r = x | y;
         OP_XOR: r = x ^ y;
         OP_COM: begin
            r = ~x; co_lo = 1'b1; co_top = 1'b1;
         end
         OP_ASL, OP_ROL: begin
            r      = {x[XW-2:0], (op == OP_ROL) ? cin : 1'b0};
            co_lo  = x[NW-1];
            co_top = x[top];
         end
         OP_ASR, OP_LSR, OP_ROR: begin
            r      = {1'b0, x[XW-1:1]};
            r[top] = (op == OP_ASR) ? x[top] : ((op == OP_ROR) ? cin : 1'b0);
            co_lo  = x[0];
            co_top = x[0];
         end
         OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP,
         OP_INC, OP_DEC, OP_NEG: ;
         default: r = y;
      endcase
   end

   assign n_out = r[top];
   assign z_out = ((r & mask) == '0);

endmodule

// File: rtl/wxalu_shape.sv
module wxalu_shape
   import wxalu_pkg::*;
#(
   parameter int NW = 8,
   parameter int AW = 16,
   parameter int XW = 32
) (
   input  alu_op_e         op,
   input  dst_e            dst,
   input  logic            wide,
   input  logic [XW-1:0]   opa,
   input  logic [XW-1:0]   r,
   output logic [XW-1:0]   res
);

   localparam int EXT8  = XW - NW;
   localparam int EXT16 = XW - AW;
   localparam int PFILL = AW - NW;

   logic [XW-1:0] sx8, sx16, pair_ext, pair_mrg;

   assign sx8      = {{EXT8{r[NW-1]}}, r[NW-1:0]};
   assign sx16     = {{EXT16{r[AW-1]}}, r[AW-1:0]};
   assign pair_ext = {{PFILL{r[AW-1]}}, r[AW-1:NW], {PFILL{r[NW-1]}}, r[NW-1:0]};

   always_comb begin
      pair_mrg                = opa;
      pair_mrg[AW+NW-1:AW]    = r[AW-1:NW];
      pair_mrg[NW-1:0]        = r[NW-1:0];
   end

   always_comb begin
      if (op == OP_CMP) begin
         res = opa;
      end else if (is_shift(op)) begin
         case (dst)
            DST_ACC:  res = wide ? {opa[XW-1:AW], r[AW-1:0]} : {opa[XW-1:NW], r[NW-1:0]};
            DST_PAIR: res = wide ? r : pair_mrg;
            default:  res = wide ? r : {opa[XW-1:AW], r[AW-1:0]};
         endcase
      end else begin
         case (dst)
            DST_ACC:  res = wide ? sx16 : sx8;
            DST_PAIR: res = wide ? r : pair_ext;
            default:  res = wide ? r : sx16;
         endcase
      end
   end

endmodule

// File: rtl/wxalu_flags.sv
module wxalu_flags
   import wxalu_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    en,
   input  alu_op_e op,
   input  logic    wide,
   input  logic    co_lo,
   input  logic    co_top,
   input  logic    v_in,
   input  logic    n_in,
   input  logic    z_in,
   output logic    cin,
   output flags_t  flags_q
);

   flags_t nxt;
   logic   upd_carry;

   assign cin = wide ? flags_q.w : flags_q.c;

   always_comb begin
      nxt       = flags_q;
      nxt.n     = n_in;
      nxt.z     = z_in;
      upd_carry = 1'b0;
      if (is_arith(op)) begin
         nxt.v     = v_in;
         upd_carry = (op != OP_INC) && (op != OP_DEC);
      end else if (is_shift(op)) begin
         upd_carry = 1'b1;
         if (!is_right(op)) begin
            nxt.v = n_in ^ co_top;
         end
      end else if (op == OP_COM) begin
         nxt.v     = 1'b0;
         upd_carry = 1'b1;
      end else begin
         nxt.v = 1'b0;
      end
      if (upd_carry) begin
         if (wide) begin
            nxt.w = co_top;
            nxt.c = co_lo;
         end else begin
            nxt.c = co_top;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
      end else if (en) begin
         flags_q <= nxt;
      end
   end

endmodule

// File: rtl/wide_acc_alu.sv
module wide_acc_alu
   import wxalu_pkg::*;
#(
   parameter int NARROW_W = 8,
   parameter int ACC_W    = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en_i,
   input  logic [4:0]           op_i,
   input  logic                 wide_i,
   input  logic [1:0]           dst_i,
   input  logic [2*ACC_W-1:0]   opa_i,
   input  logic [2*ACC_W-1:0]   opb_i,
   output logic [2*ACC_W-1:0]   res_o,
   output logic [4:0]           flags_o
);

   localparam int IDX_W = 2 * ACC_W;

   if (ACC_W != 2 * NARROW_W) begin : g_bad_acc
      $error("ACC_W must be twice NARROW_W");
   end
   if (NARROW_W < 2) begin : g_bad_nw
      $error("NARROW_W must be at least 2");
   end

   alu_op_e          op;
   dst_e             dst;
   width_e           wsel;
   logic [IDX_W-1:0] x, y, r;
   logic             cin, co_lo, co_top, v_raw, n_raw, z_raw;
   flags_t           flags_q;

   assign op  = alu_op_e'(op_i);
   assign dst = dst_e'(dst_i);

   wxalu_operand #(.NW(NARROW_W), .AW(ACC_W), .XW(IDX_W)) u_opnd (
      .dst  (dst),
      .wide (wide_i),
      .opa  (opa_i),
      .opb  (opb_i),
      .x    (x),
      .y    (y),
      .wsel (wsel)
   );

   wxalu_core #(.NW(NARROW_W), .AW(ACC_W), .XW(IDX_W)) u_core (
      .op     (op),
      .wsel   (wsel),
      .x      (x),
      .y      (y),
      .cin    (cin),
      .r      (r),
      .co_lo  (co_lo),
      .co_top (co_top),
      .v_out  (v_raw),
      .n_out  (n_raw),
      .z_out  (z_raw)
   );

   wxalu_shape #(.NW(NARROW_W), .AW(ACC_W), .XW(IDX_W)) u_shape (
      .op   (op),
      .dst  (dst),
      .wide (wide_i),
      .opa  (opa_i),
      .r    (r),
      .res  (res_o)
   );

   wxalu_flags u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en_i),
      .op      (op),
      .wide    (wide_i),
      .co_lo   (co_lo),
      .co_top  (co_top),
      .v_in    (v_raw),
      .n_in    (n_raw),
      .z_in    (z_raw),
      .cin     (cin),
      .flags_q (flags_q)
   );

   assign flags_o = flags_q;

endmodule

// File: rtl/wide_acc_alu_chk.sv
module wide_acc_alu_chk
   import wxalu_pkg::*;
#(
   parameter int NARROW_W = 8,
   parameter int ACC_W    = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 en_i,
   input logic [4:0]           op_i,
   input logic                 wide_i,
   input logic [1:0]           dst_i,
   input logic [2*ACC_W-1:0]   opa_i,
   input logic [2*ACC_W-1:0]   opb_i,
   input logic [2*ACC_W-1:0]   res_o,
   input logic [4:0]           flags_o
);

   localparam int XW = 2 * ACC_W;

   logic plain;
   assign plain = !is_shift(alu_op_e'(op_i)) && (op_i != OP_CMP);

   // R12: flags hold while the update enable is low
   p_flag_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> flags_o == $past(flags_o));

   // R6: a legacy-width operation never touches the wide carry
   p_keep_w_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !wide_i) |=> flags_o[4] == $past(flags_o[4]));

   // R1: legacy accumulator results carry the byte sign all the way up
   p_acc_sext_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_i == 2'd0 && !wide_i && plain) |->
         res_o[XW-1:NARROW_W] == {(XW-NARROW_W){res_o[NARROW_W-1]}});

   // R4: legacy index results carry the 16-bit sign
   p_idx_sext_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_i[1] && !wide_i && plain) |->
         res_o[XW-1:ACC_W] == {(XW-ACC_W){res_o[ACC_W-1]}});

   // R9: Z agrees with a zero shaped result for non-shift operations
   p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && plain) |=> flags_o[2] == ($past(res_o) == '0));

   // R11: compare leaves the destination image as it was
   p_cmp_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == OP_CMP) |-> res_o == opa_i);

endmodule

bind wide_acc_alu wide_acc_alu_chk #(.NARROW_W(NARROW_W), .ACC_W(ACC_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .en_i    (en_i),
   .op_i    (op_i),
   .wide_i  (wide_i),
   .dst_i   (dst_i),
   .opa_i   (opa_i),
   .opb_i   (opb_i),
   .res_o   (res_o),
   .flags_o (flags_o)
);

// File: tb/wide_acc_alu_test.sv
module wide_acc_alu_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_i = 1'b0;
   logic [4:0]  op_i = 5'd0;
   logic        wide_i = 1'b0;
   logic [1:0]  dst_i = 2'd0;
   logic [31:0] opa_i = '0;
   logic [31:0] opb_i = '0;
   logic [31:0] res_o;
   logic [4:0]  flags_o;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;   // 50 MHz

   wide_acc_alu uut (
      .clk (clk), .rst_n (rst_n), .en_i (en_i), .op_i (op_i), .wide_i (wide_i),
      .dst_i (dst_i), .opa_i (opa_i), .opb_i (opb_i), .res_o (res_o), .flags_o (flags_o)
   );

   // entry: op[114:110] wide[109] dst[108:107] a[106:75] b[74:43]
   //        pre{W,C}[42:41] exp_res[40:9] exp_flags{W,N,Z,V,C}[8:4] req[3:0]
   localparam int NV = 21;
   localparam logic [114:0] VEC [NV] = '{
      {5'd17, 1'b0, 2'd0, 32'h0000_0000, 32'h0000_00FF, 2'b00, 32'hFFFF_FFFF, 5'b01000, 4'd1},  // R1 load -1
      {5'd0,  1'b0, 2'd0, 32'h0000_1270, 32'h0000_0090, 2'b00, 32'h0000_0000, 5'b00101, 4'd6},  // R6 carry out bit 7
      {5'd1,  1'b0, 2'd0, 32'h0000_007F, 32'h0000_0000, 2'b10, 32'h0000_007F, 5'b10000, 4'd6},  // R6 cin from C not W
      {5'd1,  1'b0, 2'd0, 32'h0000_007F, 32'h0000_0000, 2'b01, 32'hFFFF_FF80, 5'b01010, 4'd6},  // R6 cin from C
      {5'd0,  1'b1, 2'd0, 32'h0000_80F0, 32'h0000_8010, 2'b00, 32'h0000_0100, 5'b10011, 4'd7},  // R7 W bit15, C bit7
      {5'd1,  1'b1, 2'd0, 32'h0000_FFFF, 32'h0000_0000, 2'b10, 32'h0000_0000, 5'b10101, 4'd7},  // R7 cin from W
      {5'd2,  1'b0, 2'd0, 32'h0000_0005, 32'h0000_0006, 2'b00, 32'hFFFF_FFFF, 5'b01001, 4'd8},  // R8 borrow
      {5'd3,  1'b0, 2'd0, 32'h0000_0010, 32'h0000_0001, 2'b01, 32'h0000_000E, 5'b00000, 4'd8},  // R8 sbc
      {5'd0,  1'b0, 2'd1, 32'h1234_5678, 32'h0000_0008, 2'b00, 32'h0034_FF80, 5'b00000, 4'd3},  // R3 pair bytes
      {5'd4,  1'b0, 2'd1, 32'hFF00_00FF, 32'h00FF_0000, 2'b00, 32'h0000_0000, 5'b00100, 4'd9},  // R9 zero at width
      {5'd17, 1'b0, 2'd2, 32'h0000_0000, 32'h0000_8000, 2'b00, 32'hFFFF_8000, 5'b01000, 4'd4},  // R4 index sext
      {5'd17, 1'b1, 2'd2, 32'h0000_0000, 32'h0000_8000, 2'b00, 32'h0000_8000, 5'b00000, 4'd4},  // R4 wide index
      {5'd16, 1'b0, 2'd0, 32'h0000_AB02, 32'h0000_0000, 2'b01, 32'h0000_AB81, 5'b01000, 4'd5},  // R5 narrow ror
      {5'd15, 1'b1, 2'd0, 32'h1234_8001, 32'h0000_0000, 2'b10, 32'h1234_0003, 5'b10010, 4'd5},  // R5 wide rol
      {5'd14, 1'b1, 2'd2, 32'h8000_0001, 32'h0000_0000, 2'b00, 32'h4000_0000, 5'b10001, 4'd7},  // R7 right shift
      {5'd7,  1'b0, 2'd0, 32'h0000_0042, 32'h0000_0042, 2'b00, 32'h0000_0042, 5'b00100, 4'd11}, // R11 compare
      {5'd11, 1'b0, 2'd0, 32'h0000_000F, 32'h0000_0000, 2'b00, 32'hFFFF_FFF0, 5'b01001, 4'd10}, // R10 com
      {5'd8,  1'b0, 2'd0, 32'h0000_007F, 32'h0000_0000, 2'b01, 32'hFFFF_FF80, 5'b01011, 4'd10}, // R10 inc keeps C
      {5'd12, 1'b0, 2'd1, 32'h0040_00C0, 32'h0000_0000, 2'b00, 32'h0081_0080, 5'b01010, 4'd10}, // R10 asl V
      {5'd10, 1'b1, 2'd0, 32'h0000_8000, 32'h0000_0000, 2'b00, 32'hFFFF_8000, 5'b11010, 4'd2},  // R2 neg 0x8000
      {5'd9,  1'b0, 2'd2, 32'h0000_0000, 32'h0000_0000, 2'b00, 32'hFFFF_FFFF, 5'b01000, 4'd4}   // R4 dec index
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   logic [31:0] last_res;

   task automatic run(input logic [4:0] op, input logic wd, input logic [1:0] dst,
                      input logic [31:0] a, input logic [31:0] b, input logic en);
      @(negedge clk);
      op_i = op; wide_i = wd; dst_i = dst; opa_i = a; opb_i = b; en_i = en;
      #2 last_res = res_o;
      @(negedge clk);
      en_i = 1'b0;
   endtask

   // preset W and C through ordinary operations
   task automatic preset(input logic w, input logic c);
      if (w) run(5'd11, 1'b1, 2'd0, 32'h0, 32'h0, 1'b1);
      else   run(5'd0,  1'b1, 2'd0, 32'h0, 32'h0, 1'b1);
      if (c != w) begin
         if (c) run(5'd11, 1'b0, 2'd0, 32'h0, 32'h0, 1'b1);
         else   run(5'd0,  1'b0, 2'd0, 32'h0, 32'h0, 1'b1);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R12 reset flags", {27'd0, flags_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 flags after release", {27'd0, flags_o}, 32'd0);

      for (int i = 0; i < NV; i++) begin
         logic [114:0] e;
         e = VEC[i];
         preset(e[42], e[41]);
         run(e[114:110], e[109], e[108:107], e[106:75], e[74:43], 1'b1);
         chk($sformatf("R%0d vec%0d res", e[3:0], i), last_res, e[40:9]);
         chk($sformatf("R%0d vec%0d flags", e[3:0], i), {27'd0, flags_o}, {27'd0, e[8:4]});
      end

      // R12: disabled update holds all flags (preset gives W1 N1 Z0 V0 C1)
      preset(1'b1, 1'b1);
      chk("R12 preset flags", {27'd0, flags_o}, 32'h19);
      run(5'd0, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0);
      chk("R12 hold result still computed", last_res, 32'h0);
      chk("R12 hold flags", {27'd0, flags_o}, 32'h19);

      // R13: unused code behaves as load
      preset(1'b0, 1'b0);
      run(5'd25, 1'b0, 2'd0, 32'h0000_1111, 32'h0000_0080, 1'b1);
      chk("R13 unused code loads", last_res, 32'hFFFF_FF80);
      chk("R13 unused code flags", {27'd0, flags_o}, 32'h08);

      // R2: wide accumulator add with positive result stays positive
      preset(1'b0, 1'b0);
      run(5'd0, 1'b1, 2'd0, 32'hABCD_1200, 32'h0000_0034, 1'b1);
      chk("R2 wide acc sext", last_res, 32'h0000_1234);

      // R5: wide pair shift replaces all 32 bits
      preset(1'b0, 1'b0);
      run(5'd13, 1'b1, 2'd1, 32'h8000_0002, 32'h0, 1'b1);
      chk("R5 wide pair asr", last_res, 32'hC000_0001);
      chk("R5 wide pair asr flags", {27'd0, flags_o}, 32'h08);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule